// File: doc/BRIEF.md
# Multichannel Limit Alert Monitor

This block watches the stream of conversion results from a multiplexed converter. Each result arrives as a strobe with a channel number and an unsigned 12-bit sample. The sample is compared against a high and a low threshold held for that channel. The block also keeps the smallest and the largest result seen on each channel.

A limit violation sets a sticky status flag. Once a flag has been set, the same side of that channel is disarmed. It is armed again only when a later result has come back inside the limit by at least that channel's hysteresis margin. This stops a noisy signal that sits on a threshold from raising the alert over and over.

A single shared output drives an active-low, open-drain style pin, modelled here as an output enable. In alert mode it is asserted when alerts are enabled and any status flag is set. In busy mode it follows the converter's busy signal instead. Software reaches every register through a simple port: writes take effect on the next clock, and read data comes back one cycle after the request.

Top module: `lim_watch`

## Requirements
- R1: After reset, every high limit reads 0xFFF, every low limit, hysteresis and maximum reads 0, every minimum reads 0xFFF, all status flags are clear, the configuration reads 0 and `alert_oe` is 0.
- R2: A result strictly above the channel's high limit, while the high side is armed, sets that channel's high flag (status read bit 1, `alert_stat[2*ch+1]`) and disarms the high side.
- R3: A disarmed high side sets no flag, whatever the result. It re-arms on a result r with r + hysteresis <= high limit.
- R4: A result strictly below the channel's low limit, while the low side is armed, sets that channel's low flag (status read bit 0, `alert_stat[2*ch]`) and disarms the low side.
- R5: A disarmed low side sets no flag. It re-arms on a result r with r >= low limit + hysteresis.
- R6: A result equal to the high limit or to the low limit sets no flag.
- R7: Each result lowers the channel's minimum and raises its maximum as needed. Other channels' minimum and maximum are untouched.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. If a clear and a new violation of the same flag fall in the same cycle, the flag ends set.
- R9: With configuration bit 1 = 0 (alert mode), `alert_oe` is 1 exactly when configuration bit 0 (enable) is 1 and at least one flag is set. Disabling the alert does not clear the flags.
- R10: With configuration bit 1 = 1 (busy mode), `alert_oe` equals `conv_busy` and ignores the flags.
- R11: The register address is {kind[2:0], channel[2:0]}. The kinds are 0 high limit, 1 low limit, 2 hysteresis, 3 minimum, 4 maximum, 5 status, 6 configuration (channel bits ignored). `rd_valid` and `rd_data` follow `rd_en` by one cycle, and writes to the minimum and maximum kinds are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | 3 | Channel of the result |
| res_val | input | 12 | Result value, straight binary |
| conv_busy | input | 1 | Converter busy indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {kind, channel} |
| wr_data | input | 12 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 6 | Read address {kind, channel} |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 12 | Read data |
| alert_stat | output | 16 | Sticky flags, bit 2c low and bit 2c+1 high of channel c |
| alert_oe | output | 1 | Pin pull-down enable (1 = pin driven low) |

## Verification
The hardest state to reach is a disarmed side whose flag has already been cleared by software. From the ports it looks idle, yet it must ignore further violations until the hysteresis band has been crossed. The stimulus sets a flag and clears it by a write. It then sends results just inside the limit but short of the re-arm point, then violating results that must stay silent, then the exact re-arm value, and finally one violation that must set the flag again. The same sequence is run on the low side. A further cycle puts a violation and a clear of the same flag on the same edge.

// File: rtl/lim_watch_pkg.sv
package lim_watch_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_HI   = 3'd0,
        K_LO   = 3'd1,
        K_HY   = 3'd2,
        K_MIN  = 3'd3,
        K_MAX  = 3'd4,
        K_STAT = 3'd5,
        K_CFG  = 3'd6,
        K_NONE = 3'd7
    } reg_kind_e;
endpackage

// File: rtl/lim_watch_chan.sv
module lim_watch_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] val,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic          wr_hy,
    input  logic [1:0]    clr,
    input  logic [DW-1:0] wdat,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hy_o,
    output logic [DW-1:0] mn_o,
    output logic [DW-1:0] mx_o,
    output logic          st_hi,
    output logic          st_lo
);
    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [DW-1:0] hy;
        logic [DW-1:0] mn;
        logic [DW-1:0] mx;
        logic          sh;
        logic          sl;
        logic          ah;
        logic          al;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [DW:0] val_up;
    logic [DW:0] lo_up;

    always_comb begin
        st_d   = st_q;
        val_up = {1'b0, val} + {1'b0, st_q.hy};
        lo_up  = {1'b0, st_q.lo} + {1'b0, st_q.hy};
        if (wr_hi) st_d.hi = wdat;
        if (wr_lo) st_d.lo = wdat;
        if (wr_hy) st_d.hy = wdat;
        if (clr[1]) st_d.sh = 1'b0;
        if (clr[0]) st_d.sl = 1'b0;
        if (hit) begin
            if (val < st_q.mn) st_d.mn = val;
            if (val > st_q.mx) st_d.mx = val;
            if (st_q.ah) begin
                if (val > st_q.hi) begin
                    st_d.sh = 1'b1;
                    st_d.ah = 1'b0;
                end
            end else if (val_up <= {1'b0, st_q.hi}) begin
                st_d.ah = 1'b1;
            end
            if (st_q.al) begin
                if (val < st_q.lo) begin
                    st_d.sl = 1'b1;
                    st_d.al = 1'b0;
                end
            end else if ({1'b0, val} >= lo_up) begin
                st_d.al = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hi: '1, lo: '0, hy: '0, mn: '1, mx: '0,
                      sh: 1'b0, sl: 1'b0, ah: 1'b1, al: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o  = st_q.hi;
    assign lo_o  = st_q.lo;
    assign hy_o  = st_q.hy;
    assign mn_o  = st_q.mn;
    assign mx_o  = st_q.mx;
    assign st_hi = st_q.sh;
    assign st_lo = st_q.sl;

    a_r2_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.ah && val > st_q.hi) |=> (st_hi && !st_q.ah));

    a_r4_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.al && val < st_q.lo) |=> (st_lo && !st_q.al));

    a_r3_no_early_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !st_q.ah && ({1'b0, val} + {1'b0, st_q.hy}) > {1'b0, st_q.hi})
        |=> !st_q.ah);

    a_r7_min_max: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (mn_o <= $past(val) && mx_o >= $past(val)));
endmodule

// File: rtl/lim_watch_pin.sv
module lim_watch_pin #(
    parameter int NS = 16
) (
    input  logic [NS-1:0] flags,
    input  logic          alert_en,
    input  logic          busy_mode,
    input  logic          conv_busy,
    output logic          pin_oe
);
    logic any_flag;

    always_comb begin
        any_flag = |flags;
        if (busy_mode) pin_oe = conv_busy;
        else           pin_oe = alert_en & any_flag;
    end
endmodule

// File: rtl/lim_watch.sv
module lim_watch
    import lim_watch_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        res_valid,
    input  logic [$clog2(NCH)-1:0]      res_ch,
    input  logic [DW-1:0]               res_val,
    input  logic                        conv_busy,
    input  logic                        wr_en,
    input  logic [KIND_W+$clog2(NCH)-1:0] wr_addr,
    input  logic [DW-1:0]               wr_data,
    input  logic                        rd_en,
    input  logic [KIND_W+$clog2(NCH)-1:0] rd_addr,
    output logic                        rd_valid,
    output logic [DW-1:0]               rd_data,
    output logic [2*NCH-1:0]            alert_stat,
    output logic                        alert_oe
);
    localparam int CW = $clog2(NCH);
    localparam int AW = KIND_W + CW;
    localparam int NS = 2 * NCH;

    typedef struct packed {
        logic          en;
        logic          bmode;
        logic          rv;
        logic [DW-1:0] rd;
    } top_st_t;

    top_st_t tq, td;

    reg_kind_e wr_kind, rd_kind;
    logic [CW-1:0] wr_chn, rd_chn;

    logic [DW-1:0] hi_a [NCH];
    logic [DW-1:0] lo_a [NCH];
    logic [DW-1:0] hy_a [NCH];
    logic [DW-1:0] mn_a [NCH];
    logic [DW-1:0] mx_a [NCH];
    logic [NCH-1:0] sh_a, sl_a;

    assign wr_kind = reg_kind_e'(wr_addr[AW-1:CW]);
    assign rd_kind = reg_kind_e'(rd_addr[AW-1:CW]);
    assign wr_chn  = wr_addr[CW-1:0];
    assign rd_chn  = rd_addr[CW-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel_w;
        assign sel_w = wr_en && (wr_chn == CW'(c));
        lim_watch_chan #(.DW(DW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (res_valid && (res_ch == CW'(c))),
            .val   (res_val),
            .wr_hi (sel_w && wr_kind == K_HI),
            .wr_lo (sel_w && wr_kind == K_LO),
            .wr_hy (sel_w && wr_kind == K_HY),
            .clr   ((sel_w && wr_kind == K_STAT) ? wr_data[1:0] : 2'b00),
            .wdat  (wr_data),
            .hi_o  (hi_a[c]),
            .lo_o  (lo_a[c]),
            .hy_o  (hy_a[c]),
            .mn_o  (mn_a[c]),
            .mx_o  (mx_a[c]),
            .st_hi (sh_a[c]),
            .st_lo (sl_a[c])
        );
        assign alert_stat[2*c]   = sl_a[c];
        assign alert_stat[2*c+1] = sh_a[c];
    end

    always_comb begin
        td    = tq;
        td.rv = rd_en;
        if (wr_en && wr_kind == K_CFG) begin
            td.en    = wr_data[0];
            td.bmode = wr_data[1];
        end
        if (rd_en) begin
            unique case (rd_kind)
                K_HI:    td.rd = hi_a[rd_chn];
                K_LO:    td.rd = lo_a[rd_chn];
                K_HY:    td.rd = hy_a[rd_chn];
                K_MIN:   td.rd = mn_a[rd_chn];
                K_MAX:   td.rd = mx_a[rd_chn];
                K_STAT:  td.rd = {{(DW-2){1'b0}}, sh_a[rd_chn], sl_a[rd_chn]};
                K_CFG:   td.rd = {{(DW-2){1'b0}}, tq.bmode, tq.en};
                default: td.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tq <= '0;
        else        tq <= td;
    end

    assign rd_valid = tq.rv;
    assign rd_data  = tq.rd;

    lim_watch_pin #(.NS(NS)) u_pin (
        .flags     (alert_stat),
        .alert_en  (tq.en),
        .busy_mode (tq.bmode),
        .conv_busy (conv_busy),
        .pin_oe    (alert_oe)
    );

    a_r8_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == K_STAT && wr_data[1:0] == 2'b11 && !res_valid)
        |=> (alert_stat[{$past(wr_chn), 1'b0} +: 2] == 2'b00));

    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r10_busy_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (tq.bmode && conv_busy) |-> alert_oe);

    a_r9_quiet_without_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!tq.bmode && alert_stat == '0) |-> !alert_oe);
endmodule

// File: tb/lim_watch_bench.sv
module lim_watch_bench;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_ch = '0;
    logic [11:0] res_val = '0;
    logic        conv_busy = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        rd_valid;
    logic [11:0] rd_data;
    logic [15:0] alert_stat;
    logic        alert_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    lim_watch u_lim_watch (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
        .res_val(res_val), .conv_busy(conv_busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .alert_stat(alert_stat), .alert_oe(alert_oe)
    );

    // monitor: pops expected read data from the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rd_valid) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R11 unexpected read data: actual %h expected none", rd_data);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (int'(rd_data) != e) begin
                        n_err++;
                        $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                    end
                end
            end
        end
    end

    task automatic wr(input int kind, input int ch, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'((kind << 3) | ch); wr_data = 12'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic res(input int ch, input int v);
        @(negedge clk);
        res_valid = 1'b1; res_ch = 3'(ch); res_val = 12'(v);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic rd(input int kind, input int ch, input int e, input string t);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 6'((kind << 3) | ch);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input int act, input int e, input string t);
        n_chk++;
        if (act != e) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk(int'(alert_oe), 0, "R1 pin after reset");
        chk(int'(alert_stat), 0, "R1 flags after reset");
        rd(0, 0, 'hFFF, "R1 high limit reset");
        rd(1, 3, 0, "R1 low limit reset");
        rd(2, 1, 0, "R1 hysteresis reset");
        rd(3, 0, 'hFFF, "R1 minimum reset");
        rd(4, 7, 0, "R1 maximum reset");
        rd(5, 0, 0, "R1 status reset");
        rd(6, 0, 0, "R1 config reset");
        // set up channel 2
        wr(6, 0, 1);
        wr(0, 2, 'h800);
        wr(1, 2, 'h100);
        wr(2, 2, 'h40);
        rd(6, 0, 1, "R11 config readback");
        rd(2, 2, 'h40, "R11 hysteresis readback");
        res(2, 'h500);
        rd(3, 2, 'h500, "R7 first min");
        rd(4, 2, 'h500, "R7 first max");
        chk(int'(alert_oe), 0, "R9 in-range pin");
        // R2 high violation
        res(2, 'h900);
        chk(int'(alert_stat), 'h0020, "R2 high flag bit");
        chk(int'(alert_oe), 1, "R9 pin on high flag");
        rd(5, 2, 2, "R2 status high bit");
        // R8 clear
        wr(5, 2, 2);
        chk(int'(alert_stat), 0, "R8 w1c high");
        chk(int'(alert_oe), 0, "R9 pin after clear");
        // R3 hysteresis on high side
        res(2, 'h7F0);
        res(2, 'h900);
        chk(int'(alert_stat), 0, "R3 no set while disarmed");
        res(2, 'h7C0);
        chk(int'(alert_stat), 0, "R3 rearm point sets nothing");
        res(2, 'h801);
        chk(int'(alert_stat), 'h0020, "R3 set after rearm");
        wr(5, 2, 3);
        res(2, 'h800);
        chk(int'(alert_stat), 0, "R6 equal high limit");
        // R4/R5 low side
        res(2, 'h0FF);
        chk(int'(alert_stat), 'h0010, "R4 low flag bit");
        rd(5, 2, 1, "R4 status low bit");
        wr(5, 2, 2);
        chk(int'(alert_stat), 'h0010, "R8 writing 0 keeps low flag");
        wr(5, 2, 1);
        res(2, 'h130);
        res(2, 'h0F0);
        chk(int'(alert_stat), 0, "R5 no set while disarmed");
        res(2, 'h140);
        res(2, 'h100);
        chk(int'(alert_stat), 0, "R6 equal low limit");
        res(2, 'h0FF);
        chk(int'(alert_stat), 'h0010, "R5 set after rearm");
        // R7 min/max and isolation
        rd(3, 2, 'h0F0, "R7 running min");
        rd(4, 2, 'h900, "R7 running max");
        rd(3, 5, 'hFFF, "R7 other channel min");
        rd(4, 5, 0, "R7 other channel max");
        wr(3, 2, 0);
        wr(4, 2, 'hFFF);
        rd(3, 2, 'h0F0, "R11 min write ignored");
        rd(4, 2, 'h900, "R11 max write ignored");
        // R9 disable
        wr(6, 0, 0);
        chk(int'(alert_oe), 0, "R9 disabled pin");
        rd(5, 2, 1, "R9 flag kept while disabled");
        wr(6, 0, 1);
        chk(int'(alert_oe), 1, "R9 re-enabled pin");
        // R10 busy mode
        wr(6, 0, 3);
        chk(int'(alert_oe), 0, "R10 busy mode idle");
        @(negedge clk);
        conv_busy = 1'b1;
        #1;
        chk(int'(alert_oe), 1, "R10 busy mode busy");
        @(negedge clk);
        conv_busy = 1'b0;
        wr(6, 0, 1);
        wr(5, 2, 1);
        chk(int'(alert_oe), 0, "R9 all clear pin");
        // R8 set wins over clear
        @(negedge clk);
        res_valid = 1'b1; res_ch = 3'd2; res_val = 12'hA00;
        wr_en = 1'b1; wr_addr = 6'((5 << 3) | 2); wr_data = 12'd2;
        @(negedge clk);
        res_valid = 1'b0; wr_en = 1'b0;
        chk(int'(alert_stat), 'h0020, "R8 set wins over clear");
        // R6 extremes on other channels and R4 on channel 0
        res(0, 0);
        res(7, 'hFFF);
        chk(int'(alert_stat), 'h0020, "R6 full-scale and zero");
        wr(1, 0, 'h10);
        res(0, 5);
        chk(int'(alert_stat), 'h0021, "R4 channel 0 low flag");
        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R11 all reads answered");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule